// File: doc/BRIEF.md
# Write-Only Rail-Voltage Register Target on a Two-Wire Serial Bus

This block is a write-only target on a two-wire I2C-style serial bus. It sets the output voltages of a dual-rail panel supply. The analog side reads three control values from it: a 5-bit code for the positive rail, a 5-bit code for the negative rail, and an 8-bit mode byte. Rail code 1 selects 4.1 V and code 17 selects 5.7 V, in 100 mV steps. The negative rail uses the same magnitude with the opposite sign. The code that applies after reset is a parameter, so that both the 5.0 V and the 5.4 V build variants can be made from the same source.

The clock and data lines are sampled on a fast system clock, at least ten times the 400 kHz bus rate. The block finds bus events from those samples. A transfer has three parts:
- an address byte that carries the write direction;
- a register-pointer byte;
- any number of data bytes.

The target acknowledges each byte by pulling the data line low through an open-drain enable. The pointer advances after every data byte. When a value is out of range it is acknowledged but not stored.

While the enable input is low, the device is in standby. The bus interface is then silent and all three values are held at their defaults. The data and control pins are plain levels with no handshake: the serial bus paces itself, and the outputs are static register values.

Top module: `rail_reg_slave`

## Requirements
- R1: After reset, the positive and negative codes both equal DEFAULT_CODE (10 by default) and the mode byte equals MODE_DEFAULT (0x03).
- R2: Only a first byte of 0x7C is acknowledged. That byte is the 7-bit address 0111110 followed by direction bit 0. Any other first byte, including 0x7D (a read request), gets no acknowledge, and every byte after it is ignored and not acknowledged until the next START.
- R3: The byte after the address loads the register pointer. Each following data byte is written to the register the pointer selects: 0x00 is the positive code and 0x01 is the negative code, both in data bits [4:0], with bits [7:5] ignored.
- R4: The pointer increments by one after every data byte in a transfer, and wraps from 0xFF to 0x00.
- R5: A rail write is stored only when its code is in 1..17. Code 0 and codes 18..31 are acknowledged, but the previous value is kept.
- R6: A write to register 0x03 stores all 8 bits into the mode byte only when bits [1:0] are both 1. Otherwise it is acknowledged and the mode byte is kept.
- R7: Writes to pointer 0x02 or 0x04..0xFF are acknowledged and discarded, and the pointer still increments.
- R8: START is the data line falling while the clock line is high, and STOP is the data line rising while the clock line is high. A START in the middle of a transfer begins a new address phase.
- R9: While enable is low, sda_oe stays 0, nothing is acknowledged, and all three values are held at their defaults.
- R10: The acknowledge drive (sda_oe=1) starts after the falling clock edge that ends the 8th bit, and is released after the falling edge of the 9th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High = operating, low = standby |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| pos_code | output | 5 | Positive-rail voltage code |
| neg_code | output | 5 | Negative-rail voltage code |
| mode_bits | output | 8 | Mode register contents |

## Verification
The bench sends the following input patterns:
- A single write, which shows that the pointer byte and the data byte are told apart.
- Bursts across the mapped registers, an unmapped register and the 0xFF wrap, which separate correct auto-increment from a stalled or skipped pointer.
- Out-of-range codes and mode bytes with cleared low bits, mixed with valid ones, which separate rejection from truncation or clamping.
- Foreign addresses, read requests, a repeated START and transfers during standby, which show whether the address filter and bus-event detection gate writes and acknowledges correctly.

A behavioural model is compared with all three outputs on every clock, and the acknowledge level and its release are sampled on each byte.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int CODE_W   = 5;
  localparam int CODE_MIN = 1;
  localparam int CODE_MAX = 17;
  localparam logic [7:0] REG_POS  = 8'h00;
  localparam logic [7:0] REG_NEG  = 8'h01;
  localparam logic [7:0] REG_MODE = 8'h03;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} byte_kind_e;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (int'(c) >= CODE_MIN) && (int'(c) <= CODE_MAX);
  endfunction
endpackage

// File: rtl/rrs_line_sync.sv
module rrs_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe <= '1;
        prev <= 1'b1;
      end else begin
        pipe <= {pipe[STAGES-2:0], raw_i[g]};
        prev <= pipe[STAGES-1];
      end
    end
    assign lvl_o[g]  = pipe[STAGES-1];
    assign rise_o[g] = pipe[STAGES-1] & ~prev;
    assign fall_o[g] = ~pipe[STAGES-1] & prev;
  end
endmodule

// File: rtl/rrs_bus_engine.sv
module rrs_bus_engine
  import rrs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0111110,
  parameter int         BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam int               CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [BYTE_W-1:0] WR_HDR  = {DEV_ADDR, 1'b0};

  logic              active;
  byte_kind_e        kind;
  logic [CNT_W-1:0]  cnt;
  logic              ack_ph;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] ptr;
  logic              start_c, stop_c;

  assign start_c = scl_lvl & sda_fall;
  assign stop_c  = scl_lvl & sda_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; kind <= K_ADDR; cnt <= '0; ack_ph <= 1'b0;
      shreg <= '0; ptr <= '0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else if (!enable) begin
      active <= 1'b0; kind <= K_ADDR; cnt <= '0; ack_ph <= 1'b0;
      sda_oe <= 1'b0; wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        active <= 1'b1; kind <= K_ADDR; cnt <= '0;
        ack_ph <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        active <= 1'b0; cnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise && !ack_ph && cnt != LAST_BIT) begin
          shreg <= {shreg[BYTE_W-2:0], sda_lvl};
          cnt   <= cnt + CNT_W'(1);
        end else if (scl_fall && !ack_ph && cnt == LAST_BIT) begin
          ack_ph <= 1'b1;
          unique case (kind)
            K_ADDR: begin
              if (shreg == WR_HDR) sda_oe <= 1'b1;
              else                 active <= 1'b0;
            end
            K_PTR: begin
              ptr    <= shreg;
              sda_oe <= 1'b1;
            end
            default: begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= shreg;
              ptr     <= ptr + BYTE_W'(1);
              sda_oe  <= 1'b1;
            end
          endcase
        end else if (scl_fall && ack_ph) begin
          ack_ph <= 1'b0;
          sda_oe <= 1'b0;
          cnt    <= '0;
          kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
        end
      end
    end
  end
endmodule

// File: rtl/rrs_regfile.sv
module rrs_regfile
  import rrs_pkg::*;
#(
  parameter int         BYTE_W       = 8,
  parameter int         DEFAULT_CODE = 10,
  parameter logic [7:0] MODE_DEFAULT = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CODE_W-1:0] pos_code,
  output logic [CODE_W-1:0] neg_code,
  output logic [BYTE_W-1:0] mode_bits
);
  localparam logic [CODE_W-1:0] DEF_CODE = CODE_W'(DEFAULT_CODE);

  logic [CODE_W-1:0] new_code;
  logic              code_valid, mode_valid;

  assign new_code   = wr_data[CODE_W-1:0];
  assign code_valid = code_ok(new_code);
  assign mode_valid = &wr_data[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_code <= DEF_CODE; neg_code <= DEF_CODE; mode_bits <= MODE_DEFAULT;
    end else if (!enable) begin
      pos_code <= DEF_CODE; neg_code <= DEF_CODE; mode_bits <= MODE_DEFAULT;
    end else if (wr_en) begin
      case (wr_addr)
        REG_POS:  if (code_valid) pos_code  <= new_code;
        REG_NEG:  if (code_valid) neg_code  <= new_code;
        REG_MODE: if (mode_valid) mode_bits <= wr_data;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rail_reg_slave.sv
module rail_reg_slave
  import rrs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'b0111110,
  parameter int         DEFAULT_CODE = 10,
  parameter logic [7:0] MODE_DEFAULT = 8'h03,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [4:0] pos_code,
  output logic [4:0] neg_code,
  output logic [7:0] mode_bits
);
  localparam int BYTE_W = 8;

  logic [1:0] lvl, rise, fall;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data;

  rrs_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({sda_i, scl_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  rrs_bus_engine #(.DEV_ADDR(DEV_ADDR), .BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .scl_lvl(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
    .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  rrs_regfile #(.BYTE_W(BYTE_W), .DEFAULT_CODE(DEFAULT_CODE),
                .MODE_DEFAULT(MODE_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pos_code(pos_code), .neg_code(neg_code), .mode_bits(mode_bits)
  );
endmodule

// File: rtl/rail_reg_slave_chk.sv
module rail_reg_slave_chk #(
  parameter int         DEFAULT_CODE = 10,
  parameter logic [7:0] MODE_DEFAULT = 8'h03
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [4:0] pos_code,
  input logic [4:0] neg_code,
  input logic [7:0] mode_bits
);
  // R9: no drive on the bus during standby
  a_r9_quiet_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sda_oe);

  // R1 / R9: defaults held while in standby
  a_r1_defaults_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pos_code == 5'(DEFAULT_CODE) && neg_code == 5'(DEFAULT_CODE)
                 && mode_bits == MODE_DEFAULT));

  // R5: rail codes never leave the legal range
  a_r5_codes_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_code >= 5'd1 && pos_code <= 5'd17 && neg_code >= 5'd1 && neg_code <= 5'd17));

  // R6: mode byte low bits never cleared
  a_r6_mode_low_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bits[1:0] == 2'b11);

  // R10: acknowledge drive begins only while the clock line is low
  a_r10_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R10: acknowledge released only while the clock line is low
  a_r10_ack_ends_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && $past(enable)) |-> !scl_i);
endmodule

bind rail_reg_slave rail_reg_slave_chk #(
  .DEFAULT_CODE(DEFAULT_CODE), .MODE_DEFAULT(MODE_DEFAULT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_i(scl_i), .sda_oe(sda_oe),
  .pos_code(pos_code), .neg_code(neg_code), .mode_bits(mode_bits)
);

// File: tb/rail_reg_slave_test.sv
`timescale 1ns/1ps
module rail_reg_slave_test;
  localparam int Q   = 8;
  localparam int DEF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [4:0] pos_code, neg_code;
  logic [7:0] mode_bits;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  rail_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .pos_code(pos_code), .neg_code(neg_code), .mode_bits(mode_bits)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";
  int exp_pos = DEF;
  int exp_neg = DEF;
  int exp_mode = 3;
  int tx[$];

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check(int'(pos_code) == exp_pos, cur_req, "pos_code", int'(pos_code), exp_pos);
      check(int'(neg_code) == exp_neg, cur_req, "neg_code", int'(neg_code), exp_neg);
      check(int'(mode_bits) == exp_mode, cur_req, "mode_bits", int'(mode_bits), exp_mode);
    end
  end

  function automatic void model_wr(input int p, input int d);
    int c;
    c = d & 31;
    case (p & 255)
      0: if (c >= 1 && c <= 17) exp_pos = c;
      1: if (c >= 1 && c <= 17) exp_neg = c;
      3: if ((d & 3) == 3) exp_mode = d & 255;
      default: ;
    endcase
  endfunction

  task automatic bus_start();
    clks(Q); sda_m = 1'b1; clks(Q); scl_m = 1'b1; clks(2*Q);
    sda_m = 1'b0; clks(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    clks(Q); sda_m = 1'b0; clks(Q); scl_m = 1'b1; clks(2*Q); sda_m = 1'b1; clks(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit got;
    for (int i = 7; i >= 0; i--) begin
      clks(Q); sda_m = b[i]; clks(Q); scl_m = 1'b1; clks(2*Q); scl_m = 1'b0;
    end
    clks(Q); sda_m = 1'b1; clks(Q); scl_m = 1'b1; clks(Q);
    got = (sda_bus == 1'b0);
    check(got == exp_ack, req, "ack", int'(got), int'(exp_ack));
    clks(Q); scl_m = 1'b0;
    clks(6);
    check(sda_oe == 1'b0, "R10", "sda_oe after 9th fall", int'(sda_oe), 0);
  endtask

  task automatic data_byte(inout int p, input int d, input bit acked, input string req);
    cmp_en = 1'b0;
    send_byte(8'(d), acked, req);
    if (acked) model_wr(p, d);
    p = (p + 1) & 255;
    clks(1);
    cmp_en = 1'b1;
  endtask

  task automatic do_xfer(input logic [7:0] adr, input bit acked, input int ptr, input string req);
    int p;
    cur_req = req;
    bus_start();
    send_byte(adr, acked, req);
    send_byte(8'(ptr), acked, req);
    p = ptr;
    foreach (tx[i]) data_byte(p, tx[i], acked, req);
    bus_stop();
    clks(4);
  endtask

  initial begin
    int p;
    clks(5);
    rst_n = 1'b1;
    clks(2);
    cmp_en = 1'b1;
    // R1: reset state
    check(pos_code == 5'd10, "R1", "pos reset", int'(pos_code), 10);
    check(neg_code == 5'd10, "R1", "neg reset", int'(neg_code), 10);
    check(mode_bits == 8'h03, "R1", "mode reset", int'(mode_bits), 3);
    clks(20);

    // R3: single write to positive rail, upper bits ignored
    tx = '{8'hEC};
    do_xfer(8'h7C, 1'b1, 0, "R3");
    check(pos_code == 5'd12, "R3", "pos single", int'(pos_code), 12);

    // R4 / R7: burst across mapped and unmapped registers
    tx = '{17, 1, 8'hAA, 8'h0F, 8'h55};
    do_xfer(8'h7C, 1'b1, 0, "R4");
    check(neg_code == 5'd1, "R4", "neg burst", int'(neg_code), 1);
    check(mode_bits == 8'h0F, "R7", "mode after unmapped skip", int'(mode_bits), 15);

    // R4: pointer wrap from 0xFF
    tx = '{9, 5};
    do_xfer(8'h7C, 1'b1, 8'hFF, "R4");
    check(pos_code == 5'd5, "R4", "pos after wrap", int'(pos_code), 5);

    // R5: out-of-range codes ignored, in-range kept
    tx = '{0, 18};
    do_xfer(8'h7C, 1'b1, 0, "R5");
    check(pos_code == 5'd5 && neg_code == 5'd1, "R5", "codes kept", int'(pos_code), 5);
    tx = '{31, 8'hE7};
    do_xfer(8'h7C, 1'b1, 0, "R5");
    check(neg_code == 5'd7, "R5", "neg in range", int'(neg_code), 7);

    // R6: mode writes with a cleared low bit are ignored
    tx = '{8'hF2};
    do_xfer(8'h7C, 1'b1, 3, "R6");
    tx = '{8'h01};
    do_xfer(8'h7C, 1'b1, 3, "R6");
    check(mode_bits == 8'h0F, "R6", "mode kept", int'(mode_bits), 15);
    tx = '{8'hC3};
    do_xfer(8'h7C, 1'b1, 3, "R6");
    check(mode_bits == 8'hC3, "R6", "mode stored", int'(mode_bits), 195);

    // R2: foreign address and read request are not served
    tx = '{3};
    do_xfer(8'h3A, 1'b0, 0, "R2");
    tx = '{4};
    do_xfer(8'h7D, 1'b0, 0, "R2");
    check(pos_code == 5'd5, "R2", "pos untouched", int'(pos_code), 5);

    // R8: repeated START restarts the address phase
    cur_req = "R8";
    bus_start();
    send_byte(8'h7C, 1'b1, "R8");
    send_byte(8'h01, 1'b1, "R8");
    p = 1;
    data_byte(p, 8, 1'b1, "R8");
    bus_start();
    send_byte(8'h7C, 1'b1, "R8");
    send_byte(8'h00, 1'b1, "R8");
    p = 0;
    data_byte(p, 6, 1'b1, "R8");
    bus_stop();
    clks(4);
    check(pos_code == 5'd6 && neg_code == 5'd8, "R8", "pos after restart", int'(pos_code), 6);

    // R9: standby returns defaults and silences the interface
    cur_req = "R9";
    cmp_en = 1'b0;
    enable = 1'b0;
    clks(3);
    exp_pos = DEF; exp_neg = DEF; exp_mode = 3;
    cmp_en = 1'b1;
    tx = '{7};
    do_xfer(8'h7C, 1'b0, 0, "R9");
    check(pos_code == 5'd10, "R9", "pos in standby", int'(pos_code), 10);
    enable = 1'b1;
    clks(10);
    tx = '{13};
    do_xfer(8'h7C, 1'b1, 1, "R9");
    check(neg_code == 5'd13, "R9", "neg after wake", int'(neg_code), 13);

    clks(10);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
    finish_run();
  end
endmodule